// File: doc/BRIEF.md
# Weighted Slot-Table Thread Picker

This block chooses which of several hardware threads may issue in each cycle. It does not step through the threads in plain rotation. Instead it reads a small table of issue slots, and each slot names the thread that owns it. Software can give a thread more slots than the others, so that thread gets a larger share of issue bandwidth. For example, a favoured thread can hold every second slot while the remaining threads share the other half.

A slot pointer moves forward by one entry every cycle. It runs over the first L entries of the table and then returns to entry 0, so the issue order repeats once per pass for as long as the contents stay the same. Software writes table entries and the active length through plain register-style write strobes at any time. These writes land in a shadow copy. The shadow copy becomes active only at the end of a pass, so a single pass never mixes old and new contents.

The output is a thread number with a valid flag. There is no ready input and no back-pressure at this edge. Each thread instead has a stall input. If the owning thread is stalled in its slot, valid is low for that cycle and the slot is lost: it is not handed to another thread.

Top module: `slot_thread_picker`

## Requirements
- R1: After reset every table entry i holds thread i mod 4 and the active length is 4, so with no stalls the output sequence is 0,1,2,3 repeating, starting from entry 0.
- R2: In every cycle `pick_tid` equals the active entry at the slot pointer, and the pointer advances by exactly one entry per clock.
- R3: The pointer returns to entry 0 on the clock after it reaches entry L-1, so the issue order has a period of exactly L cycles.
- R4: A write with `tbl_we` high stores `tbl_tid` into entry `tbl_addr` of the shadow copy. Shadow contents, including a write made in the wrap cycle itself, become active on the clock that returns the pointer to 0, and active contents never change in the middle of a pass.
- R5: A write with `len_we` high and `len_val` from 1 to 16 sets the shadow length. It becomes the active length at the same wrap, as described in R4.
- R6: A length write with `len_val` equal to 0 or greater than 16 is ignored, and the previous length is kept.
- R7: When `thr_stall[pick_tid]` is high, `pick_valid` is low for that cycle, `pick_tid` still shows the owning thread, and the pointer still advances, so no other thread gets that slot.
- R8: Any entry may name any thread, and one thread may own several entries. With L=16 and thread 0 in every even entry, thread 0 issues in exactly 16 of any 32 consecutive unstalled cycles.
- R9: Entries at or beyond the current length keep what was written to them, and they take part once a longer length becomes active.
- R10: With L=1 every cycle is a wrap, so a write to entry 0 shows on `pick_tid` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Write strobe for one table entry |
| tbl_addr | input | 4 | Table entry to write |
| tbl_tid | input | 2 | Thread that will own the written entry |
| len_we | input | 1 | Write strobe for the active-length field |
| len_val | input | 5 | New length; legal values are 1 to 16 |
| thr_stall | input | 4 | Stall flag for each thread, bit n for thread n |
| pick_tid | output | 2 | Thread that owns the current slot |
| pick_valid | output | 1 | High when the owning thread may issue in this cycle |

## Verification
Several functions of this block can fall in the same cycle. Two matter most. The first is a table or length write arriving in the very cycle the pointer wraps: that write must already belong to the coming pass. The second is a stall of the owner in the wrap slot. The bench provokes both by issuing random writes and stalls on most cycles, including a stretch with L=1, where every cycle is a wrap. A cycle-by-cycle behavioural model of the shadow copy, the active copy and the pointer judges every cycle by comparing the expected `pick_tid` and `pick_valid` with the ports.

// File: rtl/stp_pkg.sv
package stp_pkg;

  // Legal active lengths run from one slot up to the full table.
  function automatic bit len_legal(input int unsigned value, input int unsigned max_slots);
    return (value >= 1) && (value <= max_slots);
  endfunction

endpackage

// File: rtl/stp_slot_table.sv
module stp_slot_table #(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             commit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TID_W-1:0] rd_tid
);

  logic [TID_W-1:0] act_flat [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
    logic [TID_W-1:0] shd_q;
    logic [TID_W-1:0] act_q;
    logic [TID_W-1:0] shd_nxt;
    logic             hit;

    assign hit     = wr_en && (wr_idx == IDX_W'(i));
    assign shd_nxt = hit ? wr_tid : shd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= TID_W'(i % NUM_THREADS);
        act_q <= TID_W'(i % NUM_THREADS);
      end else begin
        shd_q <= shd_nxt;
        if (commit) act_q <= shd_nxt;
      end
    end

    assign act_flat[i] = act_q;

    AST_COMMIT_COPIES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (act_q == shd_q)); // R4
  end

  assign rd_tid = act_flat[rd_idx];

endmodule

// File: rtl/stp_len_reg.sv
module stp_len_reg #(
  parameter int NUM_SLOTS   = 16,
  parameter int LEN_W       = 5,
  parameter int DEFAULT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             commit,
  output logic [LEN_W-1:0] act_len
);

  logic [LEN_W-1:0] shd_q;
  logic [LEN_W-1:0] shd_nxt;
  logic [LEN_W-1:0] act_q;
  logic             legal;

  assign legal   = stp_pkg::len_legal(int'(wr_len), NUM_SLOTS);
  assign shd_nxt = (wr_en && legal) ? wr_len : shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= LEN_W'(DEFAULT_LEN);
      act_q <= LEN_W'(DEFAULT_LEN);
    end else begin
      shd_q <= shd_nxt;
      if (commit) act_q <= shd_nxt;
    end
  end

  assign act_len = act_q;

  AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_len == '0) || (wr_len > LEN_W'(NUM_SLOTS)))) |=> (shd_q == $past(shd_q))); // R6

  AST_ACT_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != '0) && (act_q <= LEN_W'(NUM_SLOTS))); // R5

endmodule

// File: rtl/stp_slot_walker.sv
module stp_slot_walker #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] act_len,
  output logic [IDX_W-1:0] ptr,
  output logic             wrap
);

  logic [IDX_W-1:0] ptr_q;

  assign wrap = (LEN_W'(ptr_q) + LEN_W'(1)) == act_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (wrap) ptr_q <= '0;
    else           ptr_q <= ptr_q + IDX_W'(1);
  end

  assign ptr = ptr_q;

  AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(ptr_q) < act_len); // R3

  AST_PTR_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (ptr_q == $past(ptr_q) + IDX_W'(1))); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ptr_q == '0)); // R3

endmodule

// File: rtl/slot_thread_picker.sv
module slot_thread_picker #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 16,
  parameter int DEFAULT_LEN = 4,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int LEN_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_addr,
  input  logic [TID_W-1:0]       tbl_tid,
  input  logic                   len_we,
  input  logic [LEN_W-1:0]       len_val,
  input  logic [NUM_THREADS-1:0] thr_stall,
  output logic [TID_W-1:0]       pick_tid,
  output logic                   pick_valid
);

  logic [LEN_W-1:0] act_len;
  logic [IDX_W-1:0] ptr;
  logic             wrap;
  logic [TID_W-1:0] owner;

  stp_len_reg #(
    .NUM_SLOTS  (NUM_SLOTS),
    .LEN_W      (LEN_W),
    .DEFAULT_LEN(DEFAULT_LEN)
  ) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (len_we),
    .wr_len (len_val),
    .commit (wrap),
    .act_len(act_len)
  );

  stp_slot_walker #(
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_len(act_len),
    .ptr    (ptr),
    .wrap   (wrap)
  );

  stp_slot_table #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W),
    .IDX_W      (IDX_W)
  ) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (tbl_we),
    .wr_idx(tbl_addr),
    .wr_tid(tbl_tid),
    .commit(wrap),
    .rd_idx(ptr),
    .rd_tid(owner)
  );

  // A stalled owner forfeits its slot; no other thread is substituted.
  assign pick_tid   = owner;
  assign pick_valid = !thr_stall[owner];

endmodule

// File: tb/slot_thread_picker_bench.sv
`timescale 1ns/1ps
module slot_thread_picker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [1:0] tbl_tid = '0;
  logic       len_we = 1'b0;
  logic [4:0] len_val = '0;
  logic [3:0] thr_stall = '0;
  logic [1:0] pick_tid;
  logic       pick_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string req = "R1";

  // Behavioural model state.
  int m_sh [16];
  int m_act [16];
  int m_shl, m_actl, m_ptr;
  int t0_count;

  always #2.5 clk = ~clk;

  slot_thread_picker u_slot_thread_picker (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_tid(tbl_tid),
    .len_we(len_we), .len_val(len_val), .thr_stall(thr_stall),
    .pick_tid(pick_tid), .pick_valid(pick_valid)
  );

  task automatic check_eq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_sh[i] = i % 4;
      m_act[i] = i % 4;
    end
    m_shl = 4;
    m_actl = 4;
    m_ptr = 0;
  endtask

  // Called at a falling edge: drive, compare, advance model, move to next falling edge.
  task automatic step(input bit we, input int addr, input int tid,
                      input bit lwe, input int lval, input logic [3:0] stall);
    int exp_tid;
    tbl_we = we; tbl_addr = 4'(addr); tbl_tid = 2'(tid);
    len_we = lwe; len_val = 5'(lval); thr_stall = stall;
    #1;
    exp_tid = m_act[m_ptr];
    check_eq("pick_tid", int'(pick_tid), exp_tid);
    check_eq("pick_valid", int'(pick_valid), stall[exp_tid] ? 0 : 1);
    if (pick_valid && pick_tid == 2'd0) t0_count++;
    if (we) m_sh[addr] = tid;
    if (lwe && lval >= 1 && lval <= 16) m_shl = lval;
    if (m_ptr == m_actl - 1) begin
      m_ptr = 0;
      m_actl = m_shl;
      for (int i = 0; i < 16; i++) m_act[i] = m_sh[i];
    end else begin
      m_ptr++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 0, 0, 1'b0, 0, 4'b0000);
  endtask

  initial begin
    model_reset();
    #12;
    req = "R1";
    check_eq("reset pick_tid", int'(pick_tid), 0);
    check_eq("reset pick_valid", int'(pick_valid), 1);
    @(negedge clk);
    rst_n = 1'b1;

    req = "R1"; idle(4);
    req = "R2"; idle(4);
    req = "R3"; idle(8);

    // Half share for thread 0 over a 16-entry table.
    req = "R8";
    for (int i = 0; i < 16; i++)
      step(1'b1, i, (i % 2 == 0) ? 0 : 1 + ((i / 2) % 3), 1'b0, 0, 4'b0000);
    step(1'b0, 0, 0, 1'b1, 16, 4'b0000);
    idle(20);
    t0_count = 0;
    idle(32);
    check_eq("thread0 share in 32 cycles", t0_count, 16);

    req = "R4";
    for (int k = 0; k < 48; k++)
      step(($urandom % 3) == 0, $urandom % 16, $urandom % 4, 1'b0, 0, 4'b0000);

    req = "R5";
    step(1'b0, 0, 0, 1'b1, 7, 4'b0000);
    idle(30);
    step(1'b0, 0, 0, 1'b1, 3, 4'b0000);
    idle(20);

    req = "R6";
    step(1'b0, 0, 0, 1'b1, 0, 4'b0000);
    idle(10);
    step(1'b0, 0, 0, 1'b1, 20, 4'b0000);
    idle(10);
    step(1'b0, 0, 0, 1'b1, 17, 4'b0000);
    idle(10);

    req = "R7";
    for (int k = 0; k < 40; k++)
      step(1'b0, 0, 0, 1'b0, 0, 4'($urandom));

    req = "R9";
    step(1'b1, 10, 2, 1'b0, 0, 4'b0000);
    step(1'b1, 11, 3, 1'b0, 0, 4'b0000);
    step(1'b1, 12, 1, 1'b0, 0, 4'b0000);
    idle(10);
    step(1'b0, 0, 0, 1'b1, 13, 4'b0000);
    idle(30);

    req = "R10";
    step(1'b0, 0, 0, 1'b1, 1, 4'b0000);
    idle(16);
    for (int k = 0; k < 24; k++)
      step(1'b1, 0, k % 4, 1'b0, 0, 4'b0000);

    // Everything at once: writes, length changes and stalls colliding with wraps.
    req = "R4";
    for (int k = 0; k < 200; k++)
      step(($urandom % 2) == 0, $urandom % 16, $urandom % 4,
           ($urandom % 8) == 0, $urandom % 24, 4'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule